// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM with a 16-bit word and a 20-bit word address. The host issues one request at a time through a valid/ready handshake. The request carries a direction, a word address, write data and a per-byte lane mask. The sequencer turns each request into the chip-select, output-enable, write-enable and byte-lane strobe pattern that the memory expects. It holds every phase for a number of clock cycles set by a parameter, so the memory's minimum nanosecond windows are met at the chosen clock rate.

The memory data bus is split into an outgoing value, a drive enable and an incoming value, so that a pad ring or a bench can build the tri-state. The sequencer never turns on its drivers while output enable is low. When a write is accepted in the same cycle that a read completes, it first waits a parameterised number of idle cycles. During that wait the memory's output drivers finish releasing the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, and whenever no access is in progress, the memory is deselected (mem_sel_n=1, mem_sel_hi=0), mem_oe_n=1, mem_we_n=1, both mem_lane_n bits are 1, mem_dq_oe=0, req_ready=1 and rd_valid=0.
- R2: A request is taken only in a cycle where req_ready is 1. req_ready is 0 from the cycle after acceptance until the access ends. Address, mask, direction and write data are captured at acceptance, so host input changes during the access have no effect.
- R3: A read keeps the chip selected (mem_sel_n=0, mem_sel_hi=1), mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, starting the cycle after acceptance, with mem_addr equal to the accepted address.
- R4: Read data is sampled from mem_dq_in on the last read cycle. In the next cycle rd_valid is 1 for exactly one cycle and req_ready returns to 1. rd_data keeps its value until the next read completes.
- R5: Mask bit 0 enables mem_lane_n[0] (data bits 7:0) and mask bit 1 enables mem_lane_n[1] (bits 15:8). Both lane strobes are active low. A lane whose mask bit is 0 reads back as 8'h00 in rd_data.
- R6: A write holds mem_we_n low for exactly WR_CYC cycles with mem_oe_n high throughout. mem_dq_oe is 1 exactly while mem_we_n is low, and mem_dq_out carries the accepted write data.
- R7: A write accepted in the cycle where rd_valid is 1 is preceded by TA_CYC cycles in which the chip is selected and mem_we_n, mem_oe_n are high with mem_dq_oe=0. Any other write begins its write pulse in the cycle after acceptance.
- R8: A write leaves unchanged the memory bytes whose mask bit is 0, which is observable by reading the word back.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_oe_n and mem_we_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle strobe: rd_data updated |
| rd_data | output | 16 | Last read word, disabled lanes zero |
| mem_addr | output | 20 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte lane enables, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench targets a write issued in the very cycle a read finishes. A controller that skipped the turnaround would drive the bus while the memory might still be driving it, and would shorten the access by a cycle. Throughout each access the bench changes every host input to junk and keeps req_valid high. A design that did not latch its request, or that accepted while busy, would then write the wrong address or perform an extra write. Partial-mask writes followed by read-back catch a wrong lane-to-bit mapping. The bench also checks that disabled lanes, which the memory model fills with garbage, read back as zero, and it counts strobe widths to catch a pulse that is off by one.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_TURN  = 2'd1,
      PH_READ  = 2'd2,
      PH_WRITE = 2'd3
   } phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_lane.sv
module sram_seq_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              mask_in,
   input  logic [LANE_W-1:0] wbyte_in,
   input  logic              active,
   input  logic              drive,
   input  logic              capture,
   input  logic [LANE_W-1:0] dq_in,
   output logic              lane_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rd_byte
);

   logic              en_q;
   logic [LANE_W-1:0] wb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         wb_q <= '0;
      end else if (accept) begin
         en_q <= mask_in;
         wb_q <= wbyte_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_byte <= '0;
      end else if (capture) begin
         rd_byte <= en_q ? dq_in : '0;
      end
   end

   assign lane_n = !(active && en_q);
   assign dq_out = drive ? wb_q : '0;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int RD_CYC = 2,
   parameter int WR_CYC = 2,
   parameter int TA_CYC = 1,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              accept,
   input  logic              t_last,
   output logic              t_load,
   output logic [CNT_W-1:0]  t_val,
   output logic              capture,
   output logic              rd_valid,
   output logic              chip_active,
   output logic              wr_drive,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel_hi,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_dq_oe
);

   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD = CNT_W'((TA_CYC > 0) ? TA_CYC - 1 : 0);
   localparam bit               USE_TA = (TA_CYC > 0);

   phase_e            ph_q, ph_d;
   logic [ADDR_W-1:0] addr_q;

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign capture   = (ph_q == PH_READ) && t_last;

   always_comb begin
      ph_d   = ph_q;
      t_load = 1'b0;
      t_val  = '0;
      unique case (ph_q)
         PH_IDLE: begin
            if (accept) begin
               t_load = 1'b1;
               if (!req_write) begin
                  ph_d  = PH_READ;
                  t_val = RD_LD;
               end else if (USE_TA && rd_valid) begin
                  ph_d  = PH_TURN;
                  t_val = TA_LD;
               end else begin
                  ph_d  = PH_WRITE;
                  t_val = WR_LD;
               end
            end
         end
         PH_TURN: begin
            if (t_last) begin
               ph_d   = PH_WRITE;
               t_load = 1'b1;
               t_val  = WR_LD;
            end
         end
         PH_READ: begin
            if (t_last) ph_d = PH_IDLE;
         end
         PH_WRITE: begin
            if (t_last) ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         addr_q   <= '0;
         rd_valid <= 1'b0;
      end else begin
         ph_q     <= ph_d;
         rd_valid <= capture;
         if (accept) addr_q <= req_addr;
      end
   end

   assign chip_active = (ph_q != PH_IDLE);
   assign wr_drive    = (ph_q == PH_WRITE);
   assign mem_addr    = addr_q;
   assign mem_sel_n   = !chip_active;
   assign mem_sel_hi  = chip_active;
   assign mem_oe_n    = (ph_q != PH_READ);
   assign mem_we_n    = (ph_q != PH_WRITE);
   assign mem_dq_oe   = wr_drive;

   // R2: once taken, the controller is busy in the next cycle
   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R3: a read request opens the output window in the next cycle
   assert_read_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> (!mem_oe_n && !mem_sel_n && mem_sel_hi && mem_we_n));

   // R4: read strobe lasts a single cycle
   assert_rdvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R9: the two strobes never overlap
   assert_oe_we_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   generate
      if (USE_TA) begin : g_ta_chk
         // R7: write straight after a read starts with a quiet cycle
         assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && req_valid && req_ready && req_write) |=> (mem_we_n && mem_oe_n && !mem_dq_oe && !mem_sel_n));
      end else begin : g_no_ta_chk
         // R7: with no turnaround, the pulse starts at once
         assert_no_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_ready && req_write) |=> !mem_we_n);
      end
   endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int RD_CYC = 2,
   parameter int WR_CYC = 2,
   parameter int TA_CYC = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_bmask,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_sel_n,
   output logic                mem_sel_hi,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W/8-1:0] mem_lane_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_in
);

   localparam int LANES  = DATA_W / 8;
   localparam int MAXC   = max3(RD_CYC, WR_CYC, TA_CYC);
   localparam int CNT_W  = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam int WRUN_W = $clog2(WR_CYC + 2);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("sram_seq_ctrl: DATA_W must be a multiple of 8");
      end
      if (RD_CYC < 1 || WR_CYC < 1) begin : g_bad_cycles
         $error("sram_seq_ctrl: RD_CYC and WR_CYC must be at least 1");
      end
      if (TA_CYC < 0) begin : g_bad_ta
         $error("sram_seq_ctrl: TA_CYC must not be negative");
      end
   endgenerate

   logic             accept;
   logic             t_last;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             capture;
   logic             chip_active;
   logic             wr_drive;

   sram_seq_fsm #(
      .ADDR_W (ADDR_W),
      .RD_CYC (RD_CYC),
      .WR_CYC (WR_CYC),
      .TA_CYC (TA_CYC),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_ready   (req_ready),
      .accept      (accept),
      .t_last      (t_last),
      .t_load      (t_load),
      .t_val       (t_val),
      .capture     (capture),
      .rd_valid    (rd_valid),
      .chip_active (chip_active),
      .wr_drive    (wr_drive),
      .mem_addr    (mem_addr),
      .mem_sel_n   (mem_sel_n),
      .mem_sel_hi  (mem_sel_hi),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_dq_oe   (mem_dq_oe)
   );

   sram_seq_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         sram_seq_lane #(
            .LANE_W (8)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept),
            .mask_in  (req_bmask[g]),
            .wbyte_in (req_wdata[g*8 +: 8]),
            .active   (chip_active),
            .drive    (wr_drive),
            .capture  (capture),
            .dq_in    (mem_dq_in[g*8 +: 8]),
            .lane_n   (mem_lane_n[g]),
            .dq_out   (mem_dq_out[g*8 +: 8]),
            .rd_byte  (rd_data[g*8 +: 8])
         );
      end
   endgenerate

   // Width of the current write-enable low run, used by the pulse check
   logic [WRUN_W-1:0] we_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_run_q <= '0;
      else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
      else                we_run_q <= '0;
   end

   // R6: each write pulse lasts exactly WR_CYC cycles
   assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run_q == WRUN_W'(WR_CYC)));

   // R6: data drivers are on exactly while write enable is low
   assert_drive_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe == !mem_we_n);

   // R9: never drive while the memory may be driving
   assert_no_contend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R1: no lane strobe while the chip is deselected
   assert_lanes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel_n |-> (&mem_lane_n));

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

   localparam int RD = 2;
   localparam int WR = 2;
   localparam int TA = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_bmask = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [19:0] mem_addr;
   logic        mem_sel_n, mem_sel_hi, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_lane_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   sram_seq_ctrl #(
      .ADDR_W (20), .DATA_W (16), .RD_CYC (RD), .WR_CYC (WR), .TA_CYC (TA)
   ) u_sram_seq_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_bmask (req_bmask),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .mem_addr (mem_addr), .mem_sel_n (mem_sel_n), .mem_sel_hi (mem_sel_hi),
      .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n), .mem_lane_n (mem_lane_n),
      .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
   );

   // Behavioural memory: 256 words indexed by address bits 19:16 and 3:0
   logic [15:0] mem_m [256];
   int contend  = 0;
   int undriven = 0;

   function automatic logic [7:0] idx(input logic [19:0] a);
      return {a[19:16], a[3:0]};
   endfunction

   wire sel = !mem_sel_n && mem_sel_hi;

   always_comb begin
      mem_dq_in = 16'h5A5A;
      if (sel && !mem_oe_n && mem_we_n) begin
         for (int l = 0; l < 2; l++)
            mem_dq_in[l*8 +: 8] = mem_lane_n[l] ? 8'hA5 : mem_m[idx(mem_addr)][l*8 +: 8];
      end
   end

   always @(posedge clk) begin
      if (sel && !mem_we_n) begin
         for (int l = 0; l < 2; l++)
            if (!mem_lane_n[l]) mem_m[idx(mem_addr)][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      end
   end

   always @(negedge clk) begin
      if (rst_n && mem_dq_oe && !mem_oe_n) contend++;
      if (rst_n && sel && !mem_we_n && !mem_dq_oe) undriven++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Results of the last operation
   logic [15:0] got;
   bit          got_rv;
   int n_we, n_oe, n_gap, n_busy, addr_bad;

   // Called at a negedge; returns at the negedge where req_ready is back.
   task automatic op(input logic w, input logic [19:0] a,
                     input logic [15:0] d, input logic [1:0] m);
      bit seen;
      int guard;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_bmask = m;
      @(negedge clk);
      // junk while busy, request still held valid (R2)
      req_write = 1'b1; req_addr = a ^ 20'h00F0F; req_wdata = ~d; req_bmask = ~m;
      n_we = 0; n_oe = 0; n_gap = 0; n_busy = 0; addr_bad = 0; seen = 0; guard = 0;
      while (!req_ready && guard < 64) begin
         if (!mem_we_n) begin n_we++; seen = 1; end
         else if (!seen) n_gap++;
         if (!mem_oe_n) n_oe++;
         if (!mem_sel_n && mem_addr != a) addr_bad++;
         n_busy++; guard++;
         @(negedge clk);
      end
      chk(guard < 64, "R2", "access ended", guard, 0);
      got_rv = rd_valid;
      got    = rd_data;
      req_valid = 1'b0;
   endtask

   // {write, addr, wdata, mask, expected read}
   localparam int NV = 8;
   localparam logic [54:0] VEC [NV] = '{
      {1'b1, 20'h00001, 16'h1234, 2'b11, 16'h0000},
      {1'b1, 20'hF0002, 16'hABCD, 2'b11, 16'h0000},
      {1'b0, 20'h00001, 16'h0000, 2'b11, 16'h1234},
      {1'b0, 20'hF0002, 16'h0000, 2'b01, 16'h00CD},
      {1'b1, 20'h00001, 16'h55AA, 2'b10, 16'h0000},
      {1'b0, 20'h00001, 16'h0000, 2'b11, 16'h5534},
      {1'b1, 20'hF0002, 16'h9999, 2'b00, 16'h0000},
      {1'b0, 20'hF0002, 16'h0000, 2'b10, 16'hAB00}
   };

   initial begin
      logic [15:0] hold;
      for (int i = 0; i < 256; i++) mem_m[i] = 16'h0000;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(mem_sel_n && !mem_sel_hi && mem_oe_n && mem_we_n, "R1", "strobes in reset",
          {mem_sel_n, mem_sel_hi, mem_oe_n, mem_we_n}, 4'b1011);
      chk(mem_lane_n == 2'b11 && !mem_dq_oe, "R1", "lanes/drive in reset",
          {mem_lane_n, mem_dq_oe}, 3'b110);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rd_valid && mem_sel_n && mem_oe_n && mem_we_n, "R1", "idle after reset",
          {req_ready, rd_valid, mem_sel_n, mem_oe_n, mem_we_n}, 5'b10111);

      // Table walk, one idle cycle between operations
      for (int v = 0; v < NV; v++) begin
         logic        w;
         logic [19:0] a;
         logic [15:0] d, e;
         logic [1:0]  m;
         {w, a, d, m, e} = VEC[v];
         op(w, a, d, m);
         chk(addr_bad == 0, "R2", "address held during access", addr_bad, 0);
         if (w) begin
            chk(n_we == WR, "R6", "write pulse width", n_we, WR);
            chk(n_oe == 0, "R6", "oe high in write", n_oe, 0);
            chk(n_gap == 0, "R7", "no turnaround after idle", n_gap, 0);
            chk(!got_rv, "R4", "no rd_valid after write", got_rv, 0);
         end else begin
            chk(n_oe == RD, "R3", "read window width", n_oe, RD);
            chk(n_we == 0, "R2", "no write while busy", n_we, 0);
            chk(got_rv, "R4", "rd_valid at end of read", got_rv, 1);
            chk(got == e, "R5", "read data with lane mask (R8 too)", got, e);
         end
         @(negedge clk);
      end

      // R4: rd_data holds and rd_valid drops
      hold = rd_data;
      repeat (3) @(negedge clk);
      chk(!rd_valid, "R4", "rd_valid single pulse", rd_valid, 0);
      chk(rd_data == hold, "R4", "rd_data held", rd_data, hold);
      chk(req_ready && mem_sel_n && mem_lane_n == 2'b11 && !mem_dq_oe, "R1", "idle between accesses",
          {req_ready, mem_sel_n, mem_lane_n, mem_dq_oe}, 5'b11110);

      // R7: write accepted in the read's completion cycle
      op(1'b0, 20'h00003, 16'h0000, 2'b11);
      op(1'b1, 20'h00003, 16'hC3C3, 2'b11);
      chk(n_gap == TA, "R7", "turnaround cycles", n_gap, TA);
      chk(n_busy == TA + WR, "R7", "busy cycles with turnaround", n_busy, TA + WR);
      chk(n_we == WR, "R6", "write pulse after turnaround", n_we, WR);
      // back-to-back write then read then read
      op(1'b1, 20'h00004, 16'h7E81, 2'b11);
      chk(n_gap == 0, "R7", "write after write no gap", n_gap, 0);
      op(1'b0, 20'h00003, 16'h0000, 2'b11);
      chk(got == 16'hC3C3, "R6", "data after turnaround write", got, 16'hC3C3);
      op(1'b0, 20'h00004, 16'h0000, 2'b11);
      chk(n_oe == RD && n_busy == RD, "R3", "read after read timing", n_busy, RD);
      chk(got == 16'h7E81, "R4", "back-to-back read data", got, 16'h7E81);
      // masked-out bytes never change (R8): zero mask read
      op(1'b0, 20'h00004, 16'h0000, 2'b00);
      chk(got == 16'h0000, "R5", "all lanes masked reads zero", got, 0);

      chk(contend == 0, "R9", "drive while oe low", contend, 0);
      chk(undriven == 0, "R6", "write pulse without drive", undriven, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule